// File: doc/BRIEF.md
# Flash Program and Erase Command Sequencer

This block runs the command protocol of a byte-wide flash array on its own. It sits above a memory bus controller. A caller presents one of three operations: program one byte, erase a set of sectors, or erase the whole chip. The sequencer then issues the fixed unlock writes, the command write and the operand writes. After that it polls the target address with reads until the device reports completion.

The device signals progress through bit 7 of a read. While the internal operation runs, bit 7 holds the complement of the value being written. Erased memory reads 0xFF, so the expected bit for an erase is 1. A read that returns the expected bit ends the operation with a one-cycle `done` pulse. If no such read arrives within a per-operation cycle budget, the sequencer raises a sticky timeout flag instead and goes back to idle. The gap between polling reads is set on an input port.

Top module: `flash_cmd_seq`

## Requirements
- R1: A program command (`cmd_op` = 2'b01) produces exactly four bus writes, in this order: 0xAA to 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555, then `cmd_data` to `cmd_addr`.
- R2: A chip erase command (`cmd_op` = 2'b11) produces exactly six bus writes, in this order: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x10@0x5555.
- R3: A sector erase command (`cmd_op` = 2'b10) produces the first five writes of R2. It then writes 0x30 once to each selected sector, in ascending sector order. The selected set is `cmd_sect_mask` together with the sector of `cmd_addr`. A sector's address carries its index in bits 18..16 and zeros below.
- R4: After the last write, the block issues polling reads to `cmd_addr`. After a read that does not complete the operation, the next read request rises no earlier than `poll_interval`+1 cycles after that read's acknowledge.
- R5: A read with bit 7 equal to the expected bit completes the operation. The expected bit is bit 7 of `cmd_data` for a program and 1 for either erase. On completion `done` is high for exactly one cycle, in the cycle after that read's acknowledge, and `busy` falls in the same cycle.
- R6: A read that fails R5 after at least the limit has elapsed sets `timeout_err`, clears `busy` and gives no `done`. The limit is PROG_LIMIT, SECT_LIMIT or CHIP_LIMIT cycles, counted from the acknowledge of the last write.
- R7: `timeout_err` stays high while idle and is cleared when the next command is accepted.
- R8: `cmd_valid` is ignored while `busy` is high, and `cmd_op` = 2'b00 is never accepted.
- R9: After reset, `busy`, `done`, `timeout_err` and `bus_req` are all low.
- R10: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 2 | 00 none, 01 program, 10 sector erase, 11 chip erase |
| cmd_addr | input | 19 | Program target, poll address, and sector for erase |
| cmd_data | input | 8 | Byte to program |
| cmd_sect_mask | input | 8 | Extra sectors for sector erase, bit i = sector i |
| poll_interval | input | 16 | Idle cycles between polling reads |
| bus_req | output | 1 | Bus transfer request, held until acknowledge |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 19 | Transfer address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Transfer completes on this cycle |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` on reads |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Sticky timeout flag |

## Verification
Each transfer is complete when `bus_ack` is seen at a clock edge. The bench therefore raises the acknowledge at a falling edge and logs the transfer there. For the polling gap, the bench notes the cycle number of every read acknowledge and the cycle in which the next read request first appears. The gap must be at least `poll_interval`+1. `done` is due exactly one cycle after the acknowledge of the read that carries the expected bit, and the bench samples it at the next falling edge. A timeout is due no earlier than the limit after the last write's acknowledge, plus at most one polling gap.

// File: rtl/fcs_pkg.sv
// Package: operation codes, controller states and the fixed flash
// command constants shared by the sequencer modules.
package fcs_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PROG = 2'b01,
        OP_SECT = 2'b10,
        OP_CHIP = 2'b11
    } fcs_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR,
        ST_SECT,
        ST_WAIT,
        ST_RD
    } fcs_state_e;

    localparam logic [15:0] UNLOCK_A1  = 16'h5555;
    localparam logic [15:0] UNLOCK_A2  = 16'h2AAA;
    localparam logic [7:0]  KEY_1      = 8'hAA;
    localparam logic [7:0]  KEY_2      = 8'h55;
    localparam logic [7:0]  CODE_PROG  = 8'hA0;
    localparam logic [7:0]  CODE_ERASE = 8'h80;
    localparam logic [7:0]  CODE_CHIP  = 8'h10;
    localparam logic [7:0]  CODE_SECT  = 8'h30;
endpackage

// File: rtl/fcs_step_gen.sv
// Step generator: maps a write-step index and the latched operation
// to the address/data pair of that unlock or command write.
// Assumes AW >= 16 and that step 5 is only used by chip erase.
module fcs_step_gen
    import fcs_pkg::*;
#(
    parameter int AW = 19
) (
    input  logic [2:0]    step,
    input  fcs_op_e       op,
    input  logic [AW-1:0] tgt_addr,
    input  logic [7:0]    tgt_data,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);
    localparam int PADW = AW - 16;

    // Select the address/data pair for the current step.
    always_comb begin
        wr_addr = {{PADW{1'b0}}, UNLOCK_A1};
        wr_data = KEY_1;
        unique case (step)
            3'd0: begin
                wr_addr = {{PADW{1'b0}}, UNLOCK_A1};
                wr_data = KEY_1;
            end
            3'd1, 3'd4: begin
                wr_addr = {{PADW{1'b0}}, UNLOCK_A2};
                wr_data = KEY_2;
            end
            3'd2: begin
                wr_addr = {{PADW{1'b0}}, UNLOCK_A1};
                wr_data = (op == OP_PROG) ? CODE_PROG : CODE_ERASE;
            end
            3'd3: begin
                if (op == OP_PROG) begin
                    wr_addr = tgt_addr;
                    wr_data = tgt_data;
                end else begin
                    wr_addr = {{PADW{1'b0}}, UNLOCK_A1};
                    wr_data = KEY_1;
                end
            end
            3'd5: begin
                wr_addr = {{PADW{1'b0}}, UNLOCK_A1};
                wr_data = CODE_CHIP;
            end
            default: begin
                wr_addr = {{PADW{1'b0}}, UNLOCK_A1};
                wr_data = KEY_1;
            end
        endcase
    end
endmodule

// File: rtl/fcs_sector_pick.sv
// Sector picker: returns the lowest-numbered sector still pending in
// the erase mask, so sector writes go out in ascending order.
module fcs_sector_pick #(
    parameter int NSECT  = 8,
    parameter int SECT_W = $clog2(NSECT)
) (
    input  logic [NSECT-1:0]  mask,
    output logic [SECT_W-1:0] idx,
    output logic              any
);
    logic [SECT_W-1:0] cand [NSECT+1];

    // Priority chain: a lower set bit overrides every higher one.
    generate
        assign cand[NSECT] = '0;
        for (genvar i = NSECT - 1; i >= 0; i--) begin : g_prio
            assign cand[i] = mask[i] ? SECT_W'(i) : cand[i+1];
        end
    endgenerate

    assign idx = cand[0];
    assign any = |mask;

    // R3: the picked sector is always one that is pending.
    always_comb begin
        if (any) a_r3_pick_pending: assert (mask[idx]);
    end
endmodule

// File: rtl/fcs_poll_timer.sv
// Poll timer: counts total cycles since polling began (for the time
// limit) and cycles since the last read (for the polling gap).
// Assumes start and intv_clr are single-cycle strobes from the FSM.
module fcs_poll_timer #(
    parameter int TMR_W  = 34,
    parameter int INTV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run,
    input  logic              intv_clr,
    input  logic [INTV_W-1:0] interval,
    input  logic [TMR_W-1:0]  limit,
    output logic              intv_due,
    output logic              expired
);
    logic [TMR_W-1:0]  elapsed;
    logic [INTV_W-1:0] gap;

    // Total elapsed counter, saturating at its maximum.
    always_ff @(posedge clk) begin
        if (!rst_n || start)             elapsed <= '0;
        else if (run && !(&elapsed))     elapsed <= elapsed + 1'b1;
    end

    // Gap counter between polling reads, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || start || intv_clr) gap <= '0;
        else if (run && !(&gap))         gap <= gap + 1'b1;
    end

    assign expired  = (elapsed >= limit);
    assign intv_due = (gap >= interval) || expired;

    // R6: once expired, the limit stays expired until a new start.
    a_r6_expired_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && run && !start) |=> expired);
endmodule

// File: rtl/flash_cmd_seq.sv
// Flash program/erase command sequencer. Accepts one command while
// idle, emits the unlock and command writes, then polls bit 7 of the
// target until it matches the expected value or the time limit runs
// out. Assumes the bus controller holds bus_ack for one cycle per
// transfer and never acknowledges without a request.
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int AW                    = 19,
    parameter int NSECT                 = 8,
    parameter int INTV_W                = 16,
    parameter longint unsigned PROG_LIMIT = 64'd37_500,
    parameter longint unsigned SECT_LIMIT = 64'd1_875_000_000,
    parameter longint unsigned CHIP_LIMIT = 64'd8_000_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [AW-1:0]     cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic [NSECT-1:0]  cmd_sect_mask,
    input  logic [INTV_W-1:0] poll_interval,
    output logic              bus_req,
    output logic              bus_we,
    output logic [AW-1:0]     bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic              bus_ack,
    input  logic [7:0]        bus_rdata,
    output logic              busy,
    output logic              done,
    output logic              timeout_err
);
    localparam longint unsigned MAX_LIM =
        (CHIP_LIMIT > SECT_LIMIT) ?
            ((CHIP_LIMIT > PROG_LIMIT) ? CHIP_LIMIT : PROG_LIMIT) :
            ((SECT_LIMIT > PROG_LIMIT) ? SECT_LIMIT : PROG_LIMIT);
    localparam int TMR_W  = $clog2(MAX_LIM + 1) + 1;
    localparam int SECT_W = $clog2(NSECT);
    localparam int LOW_W  = AW - SECT_W;

    fcs_state_e        state;
    fcs_op_e           op_q;
    logic [AW-1:0]     addr_q;
    logic [7:0]        data_q;
    logic [NSECT-1:0]  pend_q;
    logic [2:0]        step_q;
    logic              done_q;
    logic              err_q;

    logic [AW-1:0]     step_addr;
    logic [7:0]        step_data;
    logic [SECT_W-1:0] sect_idx;
    logic              sect_any;
    logic [NSECT-1:0]  pend_next;
    logic              last_step;
    logic              exp_bit;
    logic [TMR_W-1:0]  limit;
    logic              tmr_start;
    logic              tmr_run;
    logic              intv_clr;
    logic              intv_due;
    logic              expired;
    logic              accept;

    fcs_step_gen #(.AW(AW)) u_step (
        .step     (step_q),
        .op       (op_q),
        .tgt_addr (addr_q),
        .tgt_data (data_q),
        .wr_addr  (step_addr),
        .wr_data  (step_data)
    );

    fcs_sector_pick #(.NSECT(NSECT), .SECT_W(SECT_W)) u_pick (
        .mask (pend_q),
        .idx  (sect_idx),
        .any  (sect_any)
    );

    fcs_poll_timer #(.TMR_W(TMR_W), .INTV_W(INTV_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tmr_start),
        .run      (tmr_run),
        .intv_clr (intv_clr),
        .interval (poll_interval),
        .limit    (limit),
        .intv_due (intv_due),
        .expired  (expired)
    );

    // Command decode, limit select and timer strobes.
    always_comb begin
        accept    = (state == ST_IDLE) && cmd_valid && (fcs_op_e'(cmd_op) != OP_NONE);
        last_step = (op_q == OP_PROG) ? (step_q == 3'd3) :
                    (op_q == OP_CHIP) ? (step_q == 3'd5) : (step_q == 3'd4);
        exp_bit   = (op_q == OP_PROG) ? data_q[7] : 1'b1;
        unique case (op_q)
            OP_PROG: limit = TMR_W'(PROG_LIMIT);
            OP_SECT: limit = TMR_W'(SECT_LIMIT);
            default: limit = TMR_W'(CHIP_LIMIT);
        endcase
        pend_next = pend_q & ~(NSECT'(1) << sect_idx);
        tmr_start = bus_ack && (((state == ST_WR) && last_step && (op_q != OP_SECT)) ||
                                ((state == ST_SECT) && (pend_next == '0)));
        tmr_run   = (state == ST_WAIT) || (state == ST_RD);
        intv_clr  = (state == ST_RD) && bus_ack;
    end

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_q   <= OP_NONE;
            addr_q <= '0;
            data_q <= '0;
            pend_q <= '0;
            step_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: if (accept) begin
                    op_q   <= fcs_op_e'(cmd_op);
                    addr_q <= cmd_addr;
                    data_q <= cmd_data;
                    pend_q <= (fcs_op_e'(cmd_op) == OP_SECT) ?
                              (cmd_sect_mask | (NSECT'(1) << cmd_addr[AW-1 -: SECT_W])) : '0;
                    step_q <= '0;
                    err_q  <= 1'b0;
                    state  <= ST_WR;
                end
                ST_WR: if (bus_ack) begin
                    if (!last_step)              step_q <= step_q + 3'd1;
                    else if (op_q == OP_SECT)    state  <= ST_SECT;
                    else                         state  <= ST_WAIT;
                end
                ST_SECT: if (bus_ack) begin
                    pend_q <= pend_next;
                    if (pend_next == '0) state <= ST_WAIT;
                end
                ST_WAIT: if (intv_due) state <= ST_RD;
                ST_RD: if (bus_ack) begin
                    if (bus_rdata[7] == exp_bit) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else if (expired) begin
                        err_q <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus request drive, derived from the current state.
    always_comb begin
        bus_req   = (state == ST_WR) || (state == ST_SECT) || (state == ST_RD);
        bus_we    = (state == ST_WR) || (state == ST_SECT);
        bus_addr  = addr_q;
        bus_wdata = step_data;
        if (state == ST_WR)   bus_addr = step_addr;
        if (state == ST_SECT) begin
            bus_addr  = {sect_idx, {LOW_W{1'b0}}};
            bus_wdata = CODE_SECT;
        end
        if (state == ST_RD) bus_wdata = '0;
    end

    assign busy        = (state != ST_IDLE);
    assign done        = done_q;
    assign timeout_err = err_q;

    // R10: a pending request is held unchanged until acknowledged.
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) &&
                                   $stable(bus_addr) && $stable(bus_wdata)));
    // R5: done lasts one cycle and only while idle.
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R6: a timeout never coincides with completion.
    a_r6_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (!done && !busy));
    // R8: a busy sequencer keeps its latched command.
    a_r8_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> ($stable(op_q) && $stable(addr_q) && $stable(data_q)));
    // R4: polling reads go to the latched command address.
    a_r4_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |-> (bus_addr == addr_q));
endmodule

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb;
    localparam int PL = 120, SL = 300, CL = 500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [18:0] cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic [7:0]  cmd_sect_mask = '0;
    logic [15:0] poll_interval = '0;
    logic        bus_req, bus_we, busy, done, timeout_err;
    logic [18:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_ack = 1'b0;
    logic [7:0]  bus_rdata = '0;

    flash_cmd_seq #(.PROG_LIMIT(PL), .SECT_LIMIT(SL), .CHIP_LIMIT(CL)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_sect_mask(cmd_sect_mask),
        .poll_interval(poll_interval), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .busy(busy), .done(done), .timeout_err(timeout_err)
    );

    always #4 clk = ~clk;

    int checks = 0, errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // transfer log and flash model state
    logic [18:0] wa [32];
    logic [7:0]  wd [32];
    int nw = 0, nrd = 0, ndone = 0;
    int last_wr_cyc = 0, last_rd_cyc = -100;
    int model_cnt = 0, model_delay = 0;
    logic [7:0] true_val = 8'hFF;
    logic [18:0] exp_raddr = '0;
    int pend = 0, lat = 0;
    logic prev_done = 1'b0;
    int done_cyc_err = 0, gap_err = 0, raddr_err = 0, pulse_err = 0;
    int gap_check_on = 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Bus responder, flash model and timing monitor, all at the falling edge.
    always @(negedge clk) begin
        if (model_cnt > 0) model_cnt--;
        if (done) begin
            ndone++;
            if (cyc != last_rd_cyc + 1) done_cyc_err++;
            if (prev_done) pulse_err++;
        end
        prev_done = done;
        if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (bus_req) begin
            if (pend == 0) begin
                pend = 1;
                lat = $urandom % 4;
                if (!bus_we && gap_check_on != 0 && nrd > 0 &&
                    (cyc - last_rd_cyc) < int'(poll_interval) + 1) gap_err++;
            end
            if (lat == 0) begin
                bus_ack = 1'b1;
                pend = 0;
                if (bus_we) begin
                    if (nw < 32) begin wa[nw] = bus_addr; wd[nw] = bus_wdata; end
                    nw++;
                    last_wr_cyc = cyc;
                    model_cnt = model_delay;
                end else begin
                    nrd++;
                    last_rd_cyc = cyc;
                    if (bus_addr != exp_raddr) raddr_err++;
                    bus_rdata = (model_cnt > 0) ? {~true_val[7], true_val[6:0] ^ 7'h2B} : true_val;
                end
            end else lat--;
        end
    end

    // expected write sequence
    logic [18:0] ea [32];
    logic [7:0]  ed [32];
    int ne;

    task automatic build_exp(input logic [1:0] op, input logic [18:0] a,
                             input logic [7:0] d, input logic [7:0] m);
        logic [7:0] set;
        ne = 0;
        ea[0] = 19'h05555; ed[0] = 8'hAA;
        ea[1] = 19'h02AAA; ed[1] = 8'h55;
        ea[2] = 19'h05555; ed[2] = (op == 2'b01) ? 8'hA0 : 8'h80;
        if (op == 2'b01) begin
            ea[3] = a; ed[3] = d; ne = 4;
        end else begin
            ea[3] = 19'h05555; ed[3] = 8'hAA;
            ea[4] = 19'h02AAA; ed[4] = 8'h55;
            ne = 5;
            if (op == 2'b11) begin
                ea[5] = 19'h05555; ed[5] = 8'h10; ne = 6;
            end else begin
                set = m | (8'd1 << a[18:16]);
                for (int s = 0; s < 8; s++)
                    if (set[s]) begin
                        ea[ne] = {3'(s), 16'h0}; ed[ne] = 8'h30; ne++;
                    end
            end
        end
    endtask

    function automatic string rtag(input logic [1:0] op);
        return (op == 2'b01) ? "R1" : (op == 2'b11) ? "R2" : "R3";
    endfunction

    // Issue one command; wait until idle; check sequence and outcome.
    task automatic run_cmd(input logic [1:0] op, input logic [18:0] a, input logic [7:0] d,
                           input logic [7:0] m, input int delay, input int intv,
                           input bit expect_to, input bit inject_busy_cmd);
        int t0, waitc, lim, tcyc;
        @(negedge clk);
        nw = 0; nrd = 0; ndone = 0; done_cyc_err = 0; gap_err = 0;
        raddr_err = 0; pulse_err = 0;
        model_delay = delay;
        true_val = (op == 2'b01) ? d : 8'hFF;
        exp_raddr = a;
        poll_interval = 16'(intv);
        gap_check_on = expect_to ? 0 : 1;
        build_exp(op, a, d, m);
        cmd_op = op; cmd_addr = a; cmd_data = d; cmd_sect_mask = m; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        t0 = cyc;
        chk(busy == 1'b1, "R8 accept", busy, 1);
        chk(timeout_err == 1'b0, "R7 cleared on accept", timeout_err, 0);
        if (inject_busy_cmd) begin
            cmd_op = 2'b11; cmd_addr = 19'h7FFFF; cmd_data = 8'h00; cmd_valid = 1'b1;
            repeat (3) @(negedge clk);
            cmd_valid = 1'b0;
        end
        waitc = 0;
        while (busy && waitc < 20000) begin @(negedge clk); waitc++; end
        chk(!busy, "R5 finished", busy, 0);
        tcyc = cyc;
        @(negedge clk);
        chk(nw == ne, {rtag(op), " write count"}, nw, ne);
        for (int i = 0; i < ne && i < nw; i++) begin
            chk(wa[i] == ea[i] && wd[i] == ed[i], {rtag(op), " write"},
                {wa[i], wd[i]}, {ea[i], ed[i]});
        end
        chk(raddr_err == 0, "R4 read address", raddr_err, 0);
        chk(gap_err == 0, "R4 poll gap", gap_err, 0);
        lim = (op == 2'b01) ? PL : (op == 2'b10) ? SL : CL;
        if (expect_to) begin
            chk(timeout_err == 1'b1, "R6 timeout flag", timeout_err, 1);
            chk(ndone == 0, "R6 no done", ndone, 0);
            chk((tcyc - last_wr_cyc) >= lim && (tcyc - last_wr_cyc) <= lim + intv + 12,
                "R6 timeout window", tcyc - last_wr_cyc, lim);
        end else begin
            chk(ndone == 1, "R5 single done", ndone, 1);
            chk(done_cyc_err == 0 && pulse_err == 0, "R5 done timing", done_cyc_err + pulse_err, 0);
            chk(timeout_err == 1'b0, "R6 no timeout", timeout_err, 0);
        end
        if (t0 < 0) $display("unreachable");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !timeout_err && !bus_req, "R9 reset state",
            {busy, done, timeout_err, bus_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !bus_req, "R9 idle after reset", busy, 0);

        // R8: op code 00 is never accepted
        cmd_op = 2'b00; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        nw = 0;
        repeat (10) @(negedge clk);
        chk(!busy && nw == 0, "R8 none op ignored", nw, 0);

        // directed: program with bit7=1 and bit7=0, zero interval
        run_cmd(2'b01, 19'h12345, 8'hC3, 8'h00, 20, 0, 0, 0);
        run_cmd(2'b01, 19'h00001, 8'h3C, 8'h00, 35, 3, 0, 0);
        // chip erase
        run_cmd(2'b11, 19'h40000, 8'h00, 8'h00, 40, 5, 0, 0);
        // sector erase, addr sector only, and multi-sector mask
        run_cmd(2'b10, 19'h70010, 8'h00, 8'h00, 10, 2, 0, 0);
        run_cmd(2'b10, 19'h20000, 8'h00, 8'hA5, 25, 1, 0, 0);
        // R8: command while busy ignored (log would show a chip erase)
        run_cmd(2'b01, 19'h0BEEF, 8'h81, 8'h00, 30, 2, 0, 1);
        // done on first read (device already finished)
        run_cmd(2'b01, 19'h55AA5, 8'h7E, 8'h00, 0, 4, 0, 0);

        // R6 timeouts for each operation
        run_cmd(2'b01, 19'h01000, 8'h55, 8'h00, 100000, 7, 1, 0);
        // R7: flag persists while idle
        repeat (6) @(negedge clk);
        chk(timeout_err == 1'b1, "R7 flag sticky", timeout_err, 1);
        run_cmd(2'b10, 19'h30000, 8'h00, 8'h0F, 100000, 9, 1, 0);
        run_cmd(2'b11, 19'h00000, 8'h00, 8'h00, 100000, 4, 1, 0);
        // R7: next accepted command clears the flag (checked in run_cmd)
        run_cmd(2'b01, 19'h00200, 8'h80, 8'h00, 5, 0, 0, 0);

        // random mix
        for (int k = 0; k < 20; k++) begin
            logic [1:0] op;
            op = 2'(1 + ($urandom % 3));
            run_cmd(op, 19'($urandom), 8'($urandom), 8'($urandom),
                    int'($urandom % 60), int'($urandom % 8), 0, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule